// File: doc/BRIEF.md
# Timer Status Flag Logic

This block holds the status flags of one timer channel with a 16-bit counter. It watches the counter's count events and their direction. It latches sticky flags in four cases: the counter wraps upward past its top value, the counter wraps downward past zero, compare register A or B matches the count, or a capture strobe loads the count into A or B. The status byte presents these flags to software together with the current count direction. Each flag also drives its own interrupt request, and each request has its own enable input.

Software clears a flag in two steps. It first reads the status byte while the flag is 1, which arms that flag. It then writes a 0 into the flag's position. Any write disarms every flag, so a second write cannot clear anything without a fresh read. Writing a 1 never sets a flag. When the transfer engine accepts a request raised by flag A or flag B, it can clear that flag unless its keep control is high. A set event always takes priority over a clear that arrives in the same cycle.

Top module: `timer_status_flags`

## Requirements
- R1: After reset the status byte reads 0xCC and every interrupt request is 0. This means direction (bit 7) is 1, the unused bits 6, 3 and 2 are 1, and the four flags are 0.
- R2: Bit 7 of the status byte shows the value `cnt_up` had at the previous clock edge (1 = counting up).
- R3: Overflow flag (bit 5) sets on a clock edge where `cnt_step`=1, `cnt_up`=1 and `cnt_value`=0xFFFF.
- R4: Underflow flag (bit 4) sets on a clock edge where `cnt_step`=1, `cnt_up`=0 and `cnt_value`=0x0000.
- R5: With `cap_mode[i]`=0 (compare), flag A (bit 0, i=0) or flag B (bit 1, i=1) sets on an edge where `cnt_step`=1 and `cnt_value` equals `cmp_a` or `cmp_b` respectively.
- R6: With `cap_mode[i]`=1 (capture), flag A or B sets on an edge where `cap_stb[i]`=1. A strobe in compare mode has no effect, and a compare match in capture mode has no effect.
- R7: A write of 0 to a flag that has not been read as 1 since the last write leaves that flag unchanged.
- R8: A status read returning a flag as 1 arms it. A following write with a 0 in that bit clears it. Any write disarms all flags, whatever data it carries.
- R9: Writing 1 into a flag's bit never sets or clears that flag.
- R10: `xfer_ack[i]`=1 with `xfer_keep[i]`=0 clears flag A (i=0) or B (i=1). With `xfer_keep[i]`=1 the flag stays set.
- R11: A set event in the same cycle as a clearing write or transfer clear leaves the flag at 1.
- R12: Bits 6, 3 and 2 always read 1, and writes to them have no effect.
- R13: `irq[k]` = flag k AND `irq_en[k]`, with k=0 A, 1 B, 2 overflow, 3 underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_step | input | 1 | Counter makes a count step this cycle |
| cnt_up | input | 1 | Count direction, 1 = up |
| cnt_value | input | 16 | Counter value before the step |
| cmp_a | input | 16 | Register A contents |
| cmp_b | input | 16 | Register B contents |
| cap_mode | input | 2 | Per register: 1 capture, 0 compare |
| cap_stb | input | 2 | Capture strobes for A, B |
| xfer_ack | input | 2 | Transfer engine accepted request of A, B |
| xfer_keep | input | 2 | No-clear control accompanying each acknowledge |
| bus_rd | input | 1 | Status read strobe |
| bus_wr | input | 1 | Status write strobe |
| bus_wdata | input | 8 | Write data |
| irq_en | input | 4 | Interrupt enables (A, B, overflow, underflow) |
| status | output | 8 | Status byte |
| irq | output | 4 | Interrupt requests (A, B, overflow, underflow) |

## Verification
On every cycle, the assertions check four properties of each flag. A set event forces the flag high on the next edge. A flag rises only after a set event. A flag falls only after an armed write or a transfer clear. Arming happens only after a read that saw the flag as 1. The top-level assertions also follow the direction bit and the two wrap conditions. Several behaviours can only be shown by the bench's scenarios. These are the full read-then-write clearing protocol, the disarming caused by a write of ones, the mode-dependent filtering of strobes and matches, the keep control, and the constant unused bits. The bench also sweeps the wrap boundaries, the compare values and all enable patterns.

// File: rtl/tsf_pkg.sv
package tsf_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int NUM_CHAN  = 2;
  localparam int STAT_W    = 8;
  // flag vector index
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_V = 2;
  localparam int IDX_U = 3;
  // status byte positions
  localparam int POS_A   = 0;
  localparam int POS_B   = 1;
  localparam int POS_U   = 4;
  localparam int POS_V   = 5;
  localparam int POS_DIR = 7;

  function automatic logic [STAT_W-1:0] pack_status(logic [NUM_FLAGS-1:0] f,
                                                    logic dir, logic fill);
    logic [STAT_W-1:0] s;
    s          = {STAT_W{fill}};
    s[POS_A]   = f[IDX_A];
    s[POS_B]   = f[IDX_B];
    s[POS_V]   = f[IDX_V];
    s[POS_U]   = f[IDX_U];
    s[POS_DIR] = dir;
    return s;
  endfunction

  function automatic logic [NUM_FLAGS-1:0] unpack_bits(logic [STAT_W-1:0] s);
    logic [NUM_FLAGS-1:0] f;
    f[IDX_A] = s[POS_A];
    f[IDX_B] = s[POS_B];
    f[IDX_V] = s[POS_V];
    f[IDX_U] = s[POS_U];
    return f;
  endfunction
endpackage

// File: rtl/tsf_event_detect.sv
module tsf_event_detect #(
  parameter int CNT_W = 16
) (
  input  logic                           cnt_step,
  input  logic                           cnt_up,
  input  logic [CNT_W-1:0]               cnt_value,
  input  logic [CNT_W-1:0]               cmp_a,
  input  logic [CNT_W-1:0]               cmp_b,
  input  logic [tsf_pkg::NUM_CHAN-1:0]   cap_mode,
  input  logic [tsf_pkg::NUM_CHAN-1:0]   cap_stb,
  output logic [tsf_pkg::NUM_FLAGS-1:0]  set_evt
);
  import tsf_pkg::*;
  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] BOT_VAL = '0;

  logic [CNT_W-1:0] cmp_vec [NUM_CHAN];
  assign cmp_vec[0] = cmp_a;
  assign cmp_vec[1] = cmp_b;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CHAN; gi++) begin : g_chan
      logic match_hit;
      logic cap_hit;
      always_comb begin
        match_hit = cnt_step && (cnt_value == cmp_vec[gi]) && !cap_mode[gi];
        cap_hit   = cap_stb[gi] && cap_mode[gi];
      end
      assign set_evt[gi] = match_hit | cap_hit;
    end
  endgenerate

  always_comb begin
    set_evt[IDX_V] = cnt_step &&  cnt_up && (cnt_value == TOP_VAL);
    set_evt[IDX_U] = cnt_step && !cnt_up && (cnt_value == BOT_VAL);
  end
endmodule

// File: rtl/tsf_flag_cell.sv
module tsf_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic xfer_clr,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q, flag_d, flag_en;
  logic arm_q, arm_d, arm_en;
  logic cpu_clr, any_clr;

  always_comb begin
    cpu_clr = wr_strobe && !wr_bit && arm_q;
    any_clr = cpu_clr || xfer_clr;
    flag_d  = set_evt || (flag_q && !any_clr);
    flag_en = set_evt || any_clr;
  end

  always_comb begin
    arm_en = wr_strobe || (rd_strobe && flag_q) || xfer_clr;
    if (wr_strobe)                 arm_d = 1'b0;
    else if (rd_strobe && flag_q)  arm_d = 1'b1;
    else                           arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (arm_en)  arm_q  <= arm_d;
    end
  end

  assign flag = flag_q;

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  assert_rise_needs_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt));
  assert_fall_needs_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(arm_q && wr_strobe) || $past(xfer_clr)));
  assert_arm_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> $past(rd_strobe && flag_q && !wr_strobe));
endmodule

// File: rtl/timer_status_flags.sv
module timer_status_flags #(
  parameter int   CNT_W    = 16,
  parameter logic FILL_BIT = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cnt_step,
  input  logic                          cnt_up,
  input  logic [CNT_W-1:0]              cnt_value,
  input  logic [CNT_W-1:0]              cmp_a,
  input  logic [CNT_W-1:0]              cmp_b,
  input  logic [1:0]                    cap_mode,
  input  logic [1:0]                    cap_stb,
  input  logic [1:0]                    xfer_ack,
  input  logic [1:0]                    xfer_keep,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  input  logic [7:0]                    bus_wdata,
  input  logic [3:0]                    irq_en,
  output logic [7:0]                    status,
  output logic [3:0]                    irq
);
  import tsf_pkg::*;
  localparam logic [CNT_W-1:0] TOP_VAL = {CNT_W{1'b1}};

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // direction register
  logic dir_q, dir_d, dir_en;
  always_comb begin
    dir_d  = cnt_up;
    dir_en = (dir_q != cnt_up);
  end
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q)  dir_q <= 1'b1;
    else if (dir_en)  dir_q <= dir_d;
  end

  logic [NUM_FLAGS-1:0] set_evt;
  logic [NUM_FLAGS-1:0] xfer_clr;
  logic [NUM_FLAGS-1:0] wr_bits;
  logic [NUM_FLAGS-1:0] flags;

  tsf_event_detect #(.CNT_W(CNT_W)) u_evt (
    .cnt_step  (cnt_step),
    .cnt_up    (cnt_up),
    .cnt_value (cnt_value),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cap_mode  (cap_mode),
    .cap_stb   (cap_stb),
    .set_evt   (set_evt)
  );

  always_comb begin
    xfer_clr        = '0;
    xfer_clr[IDX_A] = xfer_ack[0] && !xfer_keep[0];
    xfer_clr[IDX_B] = xfer_ack[1] && !xfer_keep[1];
    wr_bits         = unpack_bits(bus_wdata);
  end

  genvar gk;
  generate
    for (gk = 0; gk < NUM_FLAGS; gk++) begin : g_flag
      tsf_flag_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_sync_q),
        .set_evt   (set_evt[gk]),
        .xfer_clr  (xfer_clr[gk]),
        .rd_strobe (bus_rd),
        .wr_strobe (bus_wr),
        .wr_bit    (wr_bits[gk]),
        .flag      (flags[gk])
      );
    end
  endgenerate

  always_comb begin
    status = pack_status(flags, dir_q, FILL_BIT);
    irq    = flags & irq_en;
  end

  assert_dir_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    1'b1 |=> status[POS_DIR] == $past(cnt_up));
  assert_overflow_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cnt_step && cnt_up && cnt_value == TOP_VAL) |=> status[POS_V]);
  assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (cnt_step && !cnt_up && cnt_value == '0) |=> status[POS_U]);
endmodule

// File: tb/tb_timer_status_flags.sv
module tb_timer_status_flags;
  logic        clk = 0;
  logic        rst_n;
  logic        cnt_step, cnt_up;
  logic [15:0] cnt_value, cmp_a, cmp_b;
  logic [1:0]  cap_mode, cap_stb, xfer_ack, xfer_keep;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [3:0]  irq_en;
  logic [7:0]  status;
  logic [3:0]  irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  timer_status_flags dut (
    .clk(clk), .rst_n(rst_n), .cnt_step(cnt_step), .cnt_up(cnt_up),
    .cnt_value(cnt_value), .cmp_a(cmp_a), .cmp_b(cmp_b), .cap_mode(cap_mode),
    .cap_stb(cap_stb), .xfer_ack(xfer_ack), .xfer_keep(xfer_keep),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .irq_en(irq_en),
    .status(status), .irq(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply current inputs across one rising edge, then drop pulses
  task automatic tick();
    @(posedge clk); #1;
    cnt_step = 0; cap_stb = 0; xfer_ack = 0; bus_rd = 0; bus_wr = 0;
  endtask

  task automatic do_read();  bus_rd = 1; tick(); endtask
  task automatic do_write(logic [7:0] d); bus_wr = 1; bus_wdata = d; tick(); endtask
  task automatic clear_all(); do_read(); do_write(8'h00); endtask
  task automatic step_at(logic [15:0] v, logic up);
    cnt_step = 1; cnt_value = v; cnt_up = up; tick();
  endtask

  function automatic logic [7:0] exp_stat(logic d, logic v, logic u, logic b, logic a);
    return {d, 1'b1, v, u, 1'b1, 1'b1, b, a};
  endfunction

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [6];
    rst_n = 0; cnt_step = 0; cnt_up = 1; cnt_value = 16'h0100;
    cmp_a = 16'h1234; cmp_b = 16'h4321; cap_mode = 0; cap_stb = 0;
    xfer_ack = 0; xfer_keep = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0; irq_en = 4'hF;
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    repeat (3) @(posedge clk); #1;
    chk("R1 reset status", status, 8'hCC);
    chk("R1 reset irq", {4'h0, irq}, 8'h00);

    // R2 direction
    cnt_up = 0; tick();
    chk("R2 dir down", {7'h0, status[7]}, 8'h00);
    cnt_up = 1; tick();
    chk("R2 dir up", {7'h0, status[7]}, 8'h01);

    // R3 / R4 wrap sweep
    vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    for (int i = 0; i < 6; i++)
      for (int up = 0; up < 2; up++)
        for (int s = 0; s < 2; s++) begin
          logic ev, eu;
          cnt_up = up[0]; cnt_value = vals[i]; cnt_step = s[0]; tick();
          ev = s[0] && up[0] && vals[i] == 16'hFFFF;
          eu = s[0] && !up[0] && vals[i] == 16'h0000;
          chk("R3 R4 wrap sweep", status, exp_stat(up[0], ev, eu, 1'b0, 1'b0));
          clear_all();
          chk("R8 cleared after sweep", status, exp_stat(up[0], 0, 0, 0, 0));
        end
    cnt_up = 1;

    // R5 compare sweep
    cmp_a = 16'd5; cmp_b = 16'd20;
    for (int v = 0; v < 32; v++) begin
      cnt_step = 1; cnt_value = v[15:0]; tick();
      chk("R5 compare sweep", status, exp_stat(1, 0, 0, v == 20, v == 5));
      clear_all();
    end
    // no step -> no match
    cnt_value = 16'd5; tick();
    chk("R5 match needs step", status, exp_stat(1, 0, 0, 0, 0));

    // R6 capture filtering
    cap_mode = 2'b01; cap_stb = 2'b11; tick();
    chk("R6 capture A set, strobe B in compare ignored", status, exp_stat(1, 0, 0, 0, 1));
    clear_all();
    step_at(16'd5, 1);
    chk("R6 match in capture mode ignored", status, exp_stat(1, 0, 0, 0, 0));
    cap_mode = 2'b10; cap_stb = 2'b10; tick();
    chk("R6 capture B", status, exp_stat(1, 0, 0, 1, 0));
    clear_all(); cap_mode = 2'b00;

    // R7 write 0 without read
    step_at(16'd5, 1);
    do_write(8'h00);
    chk("R7 unarmed zero-write", status, exp_stat(1, 0, 0, 0, 1));
    // R8/R9 write of ones drops arm, never clears
    do_read();
    do_write(8'hFF);
    chk("R9 one-write keeps flag", status, exp_stat(1, 0, 0, 0, 1));
    do_write(8'h00);
    chk("R8 arm dropped by write", status, exp_stat(1, 0, 0, 0, 1));
    // R8 selective clear; B set after the read is not armed
    do_read();
    step_at(16'd20, 1);
    do_write(8'h00);
    chk("R8 armed A clears, unarmed B stays", status, exp_stat(1, 0, 0, 1, 0));
    clear_all();
    // R9 writing ones to cleared flags
    do_write(8'hFF);
    chk("R9 one-write does not set", status, exp_stat(1, 0, 0, 0, 0));
    // R12 unused bits
    do_write(8'h00);
    chk("R12 unused bits after zero-write", status & 8'h4C, 8'h4C);

    // R10 transfer clear
    step_at(16'd5, 1); step_at(16'd20, 1);
    xfer_ack = 2'b11; xfer_keep = 2'b10; tick();
    chk("R10 A cleared, B kept", status, exp_stat(1, 0, 0, 1, 0));
    xfer_ack = 2'b10; xfer_keep = 2'b00; tick();
    chk("R10 B cleared", status, exp_stat(1, 0, 0, 0, 0));

    // R11 set wins
    step_at(16'd5, 1);
    do_read();
    cnt_step = 1; cnt_value = 16'd5; bus_wr = 1; bus_wdata = 8'h00; tick();
    chk("R11 set beats write clear", status, exp_stat(1, 0, 0, 0, 1));
    cnt_step = 1; cnt_value = 16'd5; xfer_ack = 2'b01; tick();
    chk("R11 set beats transfer clear", status, exp_stat(1, 0, 0, 0, 1));
    clear_all();

    // R13 interrupts, all enable patterns
    step_at(16'd5, 1); step_at(16'd20, 1); step_at(16'hFFFF, 1); step_at(16'h0000, 0);
    cnt_up = 1; tick();
    chk("R13 all flags set", status, exp_stat(1, 1, 1, 1, 1));
    for (int e = 0; e < 16; e++) begin
      irq_en = e[3:0]; #1;
      chk("R13 irq gating", {4'h0, irq}, {4'h0, e[3:0]});
    end
    irq_en = 4'hF;
    clear_all();
    chk("R13 irq after clear", {4'h0, irq}, 8'h00);
    chk("R12 idle status", status, 8'hCC);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule